// File: doc/BRIEF.md
# Clock Start-up Delay Sequencer

This block keeps the system clock gated, and the core held in reset, until the selected clock source has had time to settle. A 4-bit source select picks one of three clock sources and a 2-bit settle select picks a timing option for that source. Together they give two figures. The first is a start-up cycle count, applied on every start. The second is an extra delay, applied only when the start follows a reset. That extra delay is a fixed run of settle cycles followed by zero, 4 or 64 pulses of an external millisecond timebase.

After a reset-initiated start, the sequencer runs three phases in order: the start-up cycle count, the fixed settle cycles, and the millisecond wait. It then raises clock-ready and releases the internal reset on the same edge. Once running, a wake-up request (issued after the clock stopped in power-down) drops clock-ready and repeats only the start-up count. The internal reset stays released during this. A wake-up with an external-clock setting raises a sticky warning, because those short counts do not restart cleanly from power-down. An unsupported select combination sends the sequencer to a fault state that holds clock-ready low until the next reset.

States: ST_BOOT_CNT (start-up count after reset), ST_SETTLE (fixed settle cycles), ST_MS_WAIT (counting timebase pulses), ST_READY (clock running), ST_WAKE_CNT (start-up count after wake-up), ST_FAULT (bad configuration). Transitions:
- reset to ST_BOOT_CNT
- ST_BOOT_CNT to ST_SETTLE when the count ends
- ST_SETTLE to ST_MS_WAIT when the count ends and the millisecond target is non-zero, or to ST_READY when it ends and the target is zero
- ST_MS_WAIT to ST_READY on the last pulse
- ST_READY to ST_WAKE_CNT on a wake-up request
- ST_WAKE_CNT to ST_READY when the count ends
- any state to ST_FAULT when the selection is invalid
- ST_FAULT is left only by reset

Top module: `csd_startup_seq`

## Requirements
- R1: Source code 4'b0011 (internal RC): settle codes 2'b00, 2'b01 and 2'b10 give a 1024-cycle start-up count and 2'b11 gives 16384. The extra millisecond delay is 0, 4, 64 and 0 pulses for codes 00, 01, 10 and 11.
- R2: Source code 4'b0101 (external oscillator): the start-up count is 1024 cycles for codes 00 and 01 and 16384 for codes 10 and 11. The millisecond delay is 0, 4, 4 and 64 pulses for codes 00 to 11.
- R3: Source code 4'b0001 (external clock): codes 00, 01 and 10 give a 6-cycle start-up count, with millisecond delays of 0, 4 and 64 pulses.
- R4: After reset release, clk_ready and core_rst_n stay low for N start-up edges plus 14 settle edges. They then rise together on that edge if the millisecond target is zero; otherwise they rise on the edge that samples the last target timebase pulse. ms_tick is counted once per cycle it is high, and only during the millisecond phase.
- R5: Any source code other than the three above, or 4'b0001 with settle code 2'b11, sets cfg_invalid on the next clock edge and forces clk_ready low. Both hold until reset, even if the selection becomes valid again.
- R6: While ready, a wake_req sampled high clears clk_ready on that edge. clk_ready returns high exactly N edges later, with no settle or millisecond phase. core_rst_n stays high throughout.
- R7: pd_unsafe_warn is set on the edge that accepts a wake-up while source 4'b0001 is selected, and stays set until reset. A wake-up with any other source never sets it.
- R8: Asserting rst_n low during any counting phase restarts the whole sequence from the start-up count.
- R9: wake_req has no effect outside the ready state.
- R10: While rst_n is low, clk_ready, core_rst_n, cfg_invalid and pd_unsafe_warn are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counted clock |
| rst_n | input | 1 | Power-on or external reset, asynchronous, active low |
| ms_tick | input | 1 | Millisecond timebase pulse, one count per high cycle |
| wake_req | input | 1 | Wake-up from power-down request |
| src_sel | input | 4 | Clock-source select |
| sut_sel | input | 2 | Start-up-time select |
| clk_ready | output | 1 | Registered clock-ready flag |
| core_rst_n | output | 1 | Internal reset release, active low |
| cfg_invalid | output | 1 | Invalid-configuration flag |
| pd_unsafe_warn | output | 1 | Sticky warning: wake-up with a short external-clock setting |

## Verification
The bench walks every valid select pair and times the ready edge to the exact cycle on both a reset start and a wake-up start. It holds ms_tick high through the cycle-count phases, so a design that counted pulses early, or skipped the settle run, would raise clk_ready too soon. Directed cases cover the following:
- a reset in the middle of the start-up count and in the middle of the millisecond wait, where a design that resumed instead of restarting would go ready early;
- a wake request during the start-up count, which a careless design would let shorten or restart the count;
- invalid selections before and after ready, where a non-sticky fault would let the clock come back once the select is corrected.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam logic [3:0] SRC_RC   = 4'b0011;
    localparam logic [3:0] SRC_XOSC = 4'b0101;
    localparam logic [3:0] SRC_XCLK = 4'b0001;

    typedef enum logic [2:0] {
        ST_BOOT_CNT = 3'd0,
        ST_SETTLE   = 3'd1,
        ST_MS_WAIT  = 3'd2,
        ST_READY    = 3'd3,
        ST_WAKE_CNT = 3'd4,
        ST_FAULT    = 3'd5
    } seq_state_t;

endpackage

// File: rtl/csd_cfg_decode.sv
module csd_cfg_decode
    import csd_pkg::*;
#(
    parameter int SHORT_CYC = 1024,
    parameter int LONG_CYC  = 16384,
    parameter int EXT_CYC   = 6,
    parameter int MS_SHORT  = 4,
    parameter int MS_LONG   = 64,
    parameter int CYC_W     = 15,
    parameter int MS_W      = 7
) (
    input  logic [3:0]       src_sel,
    input  logic [1:0]       sut_sel,
    output logic [CYC_W-1:0] start_cyc,
    output logic [MS_W-1:0]  ms_target,
    output logic             cfg_valid,
    output logic             pd_unsafe
);

    localparam logic [CYC_W-1:0] C_SHORT = CYC_W'(SHORT_CYC);
    localparam logic [CYC_W-1:0] C_LONG  = CYC_W'(LONG_CYC);
    localparam logic [CYC_W-1:0] C_EXT   = CYC_W'(EXT_CYC);
    localparam logic [MS_W-1:0]  M_SHORT = MS_W'(MS_SHORT);
    localparam logic [MS_W-1:0]  M_LONG  = MS_W'(MS_LONG);

    always_comb begin
        start_cyc = C_SHORT;
        ms_target = '0;
        cfg_valid = 1'b0;
        pd_unsafe = 1'b0;
        case (src_sel)
            SRC_RC: begin
                cfg_valid = 1'b1;
                start_cyc = (sut_sel == 2'b11) ? C_LONG : C_SHORT;
                case (sut_sel)
                    2'b01:   ms_target = M_SHORT;
                    2'b10:   ms_target = M_LONG;
                    default: ms_target = '0;
                endcase
            end
            SRC_XOSC: begin
                cfg_valid = 1'b1;
                start_cyc = sut_sel[1] ? C_LONG : C_SHORT;
                case (sut_sel)
                    2'b00:   ms_target = '0;
                    2'b11:   ms_target = M_LONG;
                    default: ms_target = M_SHORT;
                endcase
            end
            SRC_XCLK: begin
                start_cyc = C_EXT;
                pd_unsafe = 1'b1;
                case (sut_sel)
                    2'b00: begin cfg_valid = 1'b1; ms_target = '0;      end
                    2'b01: begin cfg_valid = 1'b1; ms_target = M_SHORT; end
                    2'b10: begin cfg_valid = 1'b1; ms_target = M_LONG;  end
                    default: cfg_valid = 1'b0;
                endcase
            end
            default: cfg_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/csd_step_counter.sv
module csd_step_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en)
            cnt <= cnt + 1'b1;
    end

    assign done = en && (cnt == limit - 1'b1);

    // The phase must end before the count passes its limit (R4)
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < limit));

endmodule

// File: rtl/csd_seq_fsm.sv
module csd_seq_fsm
    import csd_pkg::*;
#(
    parameter int CYC_W      = 15,
    parameter int MS_W       = 7,
    parameter int SETTLE_CYC = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_req,
    input  logic             ms_tick,
    input  logic             cfg_valid,
    input  logic             pd_unsafe,
    input  logic [CYC_W-1:0] start_cyc,
    input  logic [MS_W-1:0]  ms_target,
    input  logic             cyc_done,
    input  logic             ms_done,
    output logic             cyc_clr,
    output logic             cyc_en,
    output logic [CYC_W-1:0] cyc_limit,
    output logic             ms_clr,
    output logic             ms_en,
    output logic             clk_ready,
    output logic             core_rst_n,
    output logic             cfg_invalid,
    output logic             pd_unsafe_warn
);

    localparam logic [CYC_W-1:0] SETTLE_L = CYC_W'(SETTLE_CYC);

    seq_state_t state, state_nx;
    logic       wake_go;
    logic       ms_zero;

    assign ms_zero = (ms_target == '0);
    assign wake_go = (state == ST_READY) && wake_req && cfg_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_BOOT_CNT;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!cfg_valid) begin
            state_nx = ST_FAULT;
        end else begin
            unique case (state)
                ST_BOOT_CNT: if (cyc_done) state_nx = ST_SETTLE;
                ST_SETTLE:   if (cyc_done) state_nx = ms_zero ? ST_READY : ST_MS_WAIT;
                ST_MS_WAIT:  if (ms_done)  state_nx = ST_READY;
                ST_READY:    if (wake_go)  state_nx = ST_WAKE_CNT;
                ST_WAKE_CNT: if (cyc_done) state_nx = ST_READY;
                ST_FAULT:    state_nx = ST_FAULT;
                default:     state_nx = ST_FAULT;
            endcase
        end
    end

    always_comb begin
        cyc_en    = (state == ST_BOOT_CNT) || (state == ST_SETTLE) || (state == ST_WAKE_CNT);
        cyc_limit = (state == ST_SETTLE) ? SETTLE_L : start_cyc;
        ms_en     = (state == ST_MS_WAIT) && ms_tick;
        cyc_clr   = (state_nx != state);
        ms_clr    = (state_nx != state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_ready      <= 1'b0;
            core_rst_n     <= 1'b0;
            cfg_invalid    <= 1'b0;
            pd_unsafe_warn <= 1'b0;
        end else begin
            clk_ready      <= (state_nx == ST_READY);
            core_rst_n     <= core_rst_n || (state_nx == ST_READY);
            cfg_invalid    <= (state_nx == ST_FAULT);
            pd_unsafe_warn <= pd_unsafe_warn || (wake_go && pd_unsafe);
        end
    end

    assert_ready_implies_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ready |-> core_rst_n);

    assert_release_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n |=> core_rst_n);

    assert_fault_blocks_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> !clk_ready);

    assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |=> cfg_invalid);

    assert_wake_drops_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ready && wake_req) |=> (!clk_ready && core_rst_n));

    assert_warn_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pd_unsafe_warn |=> pd_unsafe_warn);

    assert_warn_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_unsafe_warn) |-> $past(pd_unsafe && wake_req));

endmodule

// File: rtl/csd_startup_seq.sv
module csd_startup_seq #(
    parameter int SHORT_CYC  = 1024,
    parameter int LONG_CYC   = 16384,
    parameter int EXT_CYC    = 6,
    parameter int SETTLE_CYC = 14,
    parameter int MS_SHORT   = 4,
    parameter int MS_LONG    = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       wake_req,
    input  logic [3:0] src_sel,
    input  logic [1:0] sut_sel,
    output logic       clk_ready,
    output logic       core_rst_n,
    output logic       cfg_invalid,
    output logic       pd_unsafe_warn
);

    localparam int CYC_W = $clog2(LONG_CYC + 1);
    localparam int MS_W  = $clog2(MS_LONG + 1);

    logic [CYC_W-1:0] start_cyc;
    logic [CYC_W-1:0] cyc_limit;
    logic [MS_W-1:0]  ms_target;
    logic cfg_valid, pd_unsafe;
    logic cyc_clr, cyc_en, cyc_done;
    logic ms_clr, ms_en, ms_done;

    csd_cfg_decode #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC),
        .EXT_CYC   (EXT_CYC),
        .MS_SHORT  (MS_SHORT),
        .MS_LONG   (MS_LONG),
        .CYC_W     (CYC_W),
        .MS_W      (MS_W)
    ) u_decode (
        .src_sel   (src_sel),
        .sut_sel   (sut_sel),
        .start_cyc (start_cyc),
        .ms_target (ms_target),
        .cfg_valid (cfg_valid),
        .pd_unsafe (pd_unsafe)
    );

    csd_step_counter #(.W(CYC_W)) u_cyc_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cyc_clr),
        .en    (cyc_en),
        .limit (cyc_limit),
        .done  (cyc_done)
    );

    csd_step_counter #(.W(MS_W)) u_ms_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ms_clr),
        .en    (ms_en),
        .limit (ms_target),
        .done  (ms_done)
    );

    csd_seq_fsm #(
        .CYC_W      (CYC_W),
        .MS_W       (MS_W),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wake_req       (wake_req),
        .ms_tick        (ms_tick),
        .cfg_valid      (cfg_valid),
        .pd_unsafe      (pd_unsafe),
        .start_cyc      (start_cyc),
        .ms_target      (ms_target),
        .cyc_done       (cyc_done),
        .ms_done        (ms_done),
        .cyc_clr        (cyc_clr),
        .cyc_en         (cyc_en),
        .cyc_limit      (cyc_limit),
        .ms_clr         (ms_clr),
        .ms_en          (ms_en),
        .clk_ready      (clk_ready),
        .core_rst_n     (core_rst_n),
        .cfg_invalid    (cfg_invalid),
        .pd_unsafe_warn (pd_unsafe_warn)
    );

endmodule

// File: tb/csd_startup_seq_tb.sv
module csd_startup_seq_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n    = 1'b0;
    logic       ms_tick  = 1'b0;
    logic       wake_req = 1'b0;
    logic [3:0] src_sel  = 4'b0011;
    logic [1:0] sut_sel  = 2'b00;
    logic clk_ready, core_rst_n, cfg_invalid, pd_unsafe_warn;

    int  checks = 0;
    int  fails  = 0;
    bit  all_done = 1'b0;

    csd_startup_seq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ms_tick        (ms_tick),
        .wake_req       (wake_req),
        .src_sel        (src_sel),
        .sut_sel        (sut_sel),
        .clk_ready      (clk_ready),
        .core_rst_n     (core_rst_n),
        .cfg_invalid    (cfg_invalid),
        .pd_unsafe_warn (pd_unsafe_warn)
    );

    // {source[29:26], settle code[25:24], start-up cycles[23:8], ms pulses[7:0]}
    localparam logic [29:0] VEC [11] = '{
        {4'b0011, 2'b00, 16'd1024,  8'd0},
        {4'b0011, 2'b01, 16'd1024,  8'd4},
        {4'b0011, 2'b10, 16'd1024,  8'd64},
        {4'b0011, 2'b11, 16'd16384, 8'd0},
        {4'b0101, 2'b00, 16'd1024,  8'd0},
        {4'b0101, 2'b01, 16'd1024,  8'd4},
        {4'b0101, 2'b10, 16'd16384, 8'd4},
        {4'b0101, 2'b11, 16'd16384, 8'd64},
        {4'b0001, 2'b00, 16'd6,     8'd0},
        {4'b0001, 2'b01, 16'd6,     8'd4},
        {4'b0001, 2'b10, 16'd6,     8'd64}
    };

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [3:0] s, input logic [1:0] u);
        @(negedge clk);
        src_sel = s; sut_sel = u; rst_n = 1'b0; ms_tick = 1'b0; wake_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(clk_ready,      1'b0, "R10 clk_ready in reset");
        chk(core_rst_n,     1'b0, "R10 core_rst_n in reset");
        chk(cfg_invalid,    1'b0, "R10 cfg_invalid in reset");
        chk(pd_unsafe_warn, 1'b0, "R10 warn in reset");
        rst_n = 1'b1;
    endtask

    // Called right after reset release at a falling edge (R4 timing).
    task automatic run_boot(input int n, input int ms, input string tag);
        ms_tick = 1'b1;
        repeat (n + 13) @(negedge clk);
        chk(clk_ready,  1'b0, {tag, " R4 ready before settle end"});
        chk(core_rst_n, 1'b0, {tag, " R4 release before settle end"});
        @(negedge clk);
        ms_tick = 1'b0;
        if (ms == 0) begin
            chk(clk_ready,  1'b1, {tag, " R4 ready at settle end"});
            chk(core_rst_n, 1'b1, {tag, " R4 release at settle end"});
        end else begin
            chk(clk_ready, 1'b0, {tag, " R4 ready before ms phase"});
            for (int k = 1; k <= ms; k++) begin
                ms_tick = 1'b1;
                @(negedge clk);
                ms_tick = 1'b0;
                if (k == ms - 1) chk(clk_ready, 1'b0, {tag, " R4 ready one pulse early"});
                if (k == ms) begin
                    chk(clk_ready,  1'b1, {tag, " R4 ready after last pulse"});
                    chk(core_rst_n, 1'b1, {tag, " R4 release after last pulse"});
                end
            end
        end
    endtask

    task automatic run_wake(input int n, input logic ext, input string tag);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        chk(clk_ready,      1'b0, {tag, " R6 ready drops on wake"});
        chk(core_rst_n,     1'b1, {tag, " R6 release kept on wake"});
        chk(pd_unsafe_warn, ext,  {tag, " R7 warning on wake"});
        repeat (n - 1) @(negedge clk);
        chk(clk_ready, 1'b0, {tag, " R6 ready early after wake"});
        @(negedge clk);
        chk(clk_ready, 1'b1, {tag, " R6 ready after wake count"});
        chk(pd_unsafe_warn, ext, {tag, " R7 warning held"});
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!all_done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        string tg;
        // Vector walk: every valid selection, reset start then wake start (R1 R2 R3)
        for (int i = 0; i < 11; i++) begin
            if (VEC[i][29:26] == 4'b0011)      tg = "R1";
            else if (VEC[i][29:26] == 4'b0101) tg = "R2";
            else                               tg = "R3";
            apply_reset(VEC[i][29:26], VEC[i][25:24]);
            run_boot(int'(VEC[i][23:8]), int'(VEC[i][7:0]), tg);
            @(negedge clk);
            run_wake(int'(VEC[i][23:8]), VEC[i][29:26] == 4'b0001, tg);
        end

        // R8: reset during the start-up count restarts the sequence
        apply_reset(4'b0011, 2'b00);
        ms_tick = 1'b1;
        repeat (500) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_boot(1024, 0, "R8 restart from count");

        // R8: reset during the millisecond wait restarts the sequence
        apply_reset(4'b0101, 2'b01);
        ms_tick = 1'b1;
        repeat (1038) @(negedge clk);
        ms_tick = 1'b0;
        for (int k = 0; k < 2; k++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_boot(1024, 4, "R8 restart from ms wait");

        // R9: wake during the start-up count leaves the timing unchanged
        apply_reset(4'b0011, 2'b00);
        repeat (10) @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        repeat (1037 - 11) @(negedge clk);
        chk(clk_ready, 1'b0, "R9 ready early after ignored wake");
        @(negedge clk);
        chk(clk_ready, 1'b1, "R9 ready on time after ignored wake");
        chk(pd_unsafe_warn, 1'b0, "R9 no warning from ignored wake");

        // R5: unlisted source code
        apply_reset(4'b0000, 2'b00);
        @(negedge clk);
        chk(cfg_invalid, 1'b1, "R5 invalid on unlisted source");
        repeat (1100) @(negedge clk);
        chk(clk_ready,   1'b0, "R5 ready held low");
        chk(core_rst_n,  1'b0, "R5 release held low");
        chk(cfg_invalid, 1'b1, "R5 invalid held");

        // R5: reserved external-clock code
        apply_reset(4'b0001, 2'b11);
        @(negedge clk);
        chk(cfg_invalid, 1'b1, "R5 invalid on reserved code");
        repeat (30) @(negedge clk);
        chk(clk_ready, 1'b0, "R5 ready low on reserved code");

        // R5: invalid selection after ready, then corrected
        apply_reset(4'b0001, 2'b00);
        run_boot(6, 0, "R3");
        @(negedge clk);
        src_sel = 4'b1111;
        @(negedge clk);
        chk(cfg_invalid, 1'b1, "R5 invalid after ready");
        chk(clk_ready,   1'b0, "R5 ready dropped on invalid");
        src_sel = 4'b0011;
        repeat (20) @(negedge clk);
        chk(cfg_invalid, 1'b1, "R5 fault sticky after correction");
        chk(clk_ready,   1'b0, "R5 ready stays low after correction");

        // R10: reset clears the fault
        apply_reset(4'b0011, 2'b00);
        run_boot(1024, 0, "R10 after fault");

        all_done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule